// File: doc/BRIEF.md
# Fixed Off-Time PWM Chopper

This block sits between the commutation decoder of a three-phase bridge driver and the six gate drivers. It receives the one-hot high-side and low-side phase selections, an external PWM enable, a decay-mode bit and a digital over-current flag from an off-chip comparator. From these it produces the six final gate commands. It regulates phase current by cutting the selected high-side gate when the current flag trips, and by holding that gate off for a programmable number of cycles. After the high-side gate turns on, the current flag is ignored for a programmable blanking window. This stops diode reverse-recovery spikes from ending the on-phase early.

While the high side is off, the winding current recirculates through low-side switches. In slow decay both low-side switches of the active phase pair conduct. In fast decay only the low side of the chopped phase conducts, so the body diode of the opposite high side carries the rest of the current and the rectification is synchronous on the low side only. Every leg passes through a dead-time stage. A gate turns off at once. A gate turns on only after both gates of its leg have been off for the programmed dead time. This holds on chopping, on PWM edges, on decay switching and on changes of the selected phases.

Off-time, blanking time and dead time are quasi-static 16-bit configuration words counted in clock cycles.

Top module: `pwm_chopper`

## Requirements
- R1: While rst_n is low, all six gate outputs are 0. After reset is released, no gate turns on before the dead time has elapsed: with dead time D, the first gates appear on the (D+1)-th rising edge after release.
- R2: A trip is accepted when trip_in is 1 in a cycle where a high-side gate is on, pwm_in is 1, the chopper is in its drive state and the blanking window is not open. After an accepted trip, gate_hi is all zeros from the second rising edge onward.
- R3: Let k = 0 be the first cycle in which a high-side gate is on. For blank_cyc = B, trip_in is ignored in cycles k < B. A trip held from k = 0 therefore removes the high-side gate B+2 cycles after it rose.
- R4: After an accepted trip, the chopper stays in recirculation for max(off_cyc,1) cycles and then re-enables the selected high side. With off_cyc = T greater than the dead time D, the high-side gate returns T+D cycles after it dropped.
- R5: With slow_decay = 1, while recirculating, the low-side outputs equal lo_sel OR hi_sel once the dead time allows. The low side that was already on stays on without a gap.
- R6: With slow_decay = 0, while recirculating, only the low side of the phase named by hi_sel is driven. The low side named by lo_sel turns off on the edge after recirculation begins.
- R7: pwm_in = 0 in a cycle forces gate_hi to all zeros after the next edge and selects the decay pattern of R5/R6. A trip_in seen while pwm_in is 0 starts no off-time, so the high side returns D+1 cycles after pwm_in rises.
- R8: Within one phase, once both gates are off, neither may turn on until both have been off for max(dead_cyc,1) consecutive cycles. Turn-off takes effect on the next edge.
- R9: When the selected phases change, every affected leg goes through the off state. The new gates appear D+1 cycles after the change, and all six outputs are 0 for the D cycles in between.
- R10: gate_hi[i] and gate_lo[i] are never 1 in the same cycle, for any phase i.
- R11: Bit i of hi_sel, lo_sel, gate_hi and gate_lo refers to phase i. In the drive state with pwm_in = 1 and legs settled, gate_hi equals hi_sel and gate_lo equals lo_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_sel | input | NPH | One-hot high-side phase selection from commutation |
| lo_sel | input | NPH | One-hot low-side phase selection from commutation |
| pwm_in | input | 1 | External PWM enable; 0 forces recirculation |
| slow_decay | input | 1 | 1 = both low sides recirculate, 0 = low side of chopped phase only |
| trip_in | input | 1 | Digital current-limit comparator flag |
| dead_cyc | input | 16 | Dead time in cycles |
| off_cyc | input | 16 | Fixed off-time in cycles |
| blank_cyc | input | 16 | Blanking window in cycles after a high-side turn-on |
| gate_hi | output | NPH | High-side gate commands |
| gate_lo | output | NPH | Low-side gate commands |

## Verification
Each result has a fixed latency that is counted through the registers on its path. The trip flag is sampled at one edge, the chopper state changes at that edge, and the gate register follows one edge later, so an accepted trip shows two cycles after it was driven. A PWM fall reaches the gates one edge after it is driven. Any gate turning on after a change waits one edge plus the dead time. The bench drives every input one time step after a rising edge and reads the outputs at that same point. It counts edges from the stimulus and compares at exactly the edge these latency counts predict. It also checks the cycle just before, so that early switching is caught as well as late switching.

// File: rtl/chop_pkg.sv
package chop_pkg;
  localparam int CNT_W = 16;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic {
    CH_DRIVE   = 1'b0,
    CH_RECIRC  = 1'b1
  } chop_st_t;

  // saturating increment of a cycle counter
  function automatic cnt_t sat_inc(input cnt_t v);
    return (v == '1) ? v : v + cnt_t'(1);
  endfunction

  // remaining blank count to load on the turn-on cycle itself
  function automatic cnt_t blank_load(input cnt_t len);
    return (len == '0) ? '0 : len - cnt_t'(1);
  endfunction

  // off-time ends when the remaining count is one or less
  function automatic logic off_done(input cnt_t left);
    return left <= cnt_t'(1);
  endfunction

  // a gate may be on next cycle: requested alone, partner off,
  // and either already on or the leg idle long enough
  function automatic logic leg_grant(input logic want, input logic want_other,
                                     input logic own_on, input logic other_on,
                                     input cnt_t idle, input cnt_t dead);
    return want && !want_other && !other_on && (own_on || idle >= dead);
  endfunction
endpackage

// File: rtl/chop_latch.sv
module chop_latch
  import chop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_in,
  input  logic trip_in,
  input  logic hs_on,
  input  logic blanking,
  input  cnt_t off_cyc,
  output logic src_en
);
  chop_st_t st;
  cnt_t     left;
  logic     trip_take;

  assign trip_take = trip_in && hs_on && !blanking && pwm_in && (st == CH_DRIVE);
  assign src_en    = (st == CH_DRIVE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= CH_DRIVE;
      left <= '0;
    end else begin
      unique case (st)
        CH_DRIVE: begin
          if (trip_take) begin
            st   <= CH_RECIRC;
            left <= off_cyc;
          end
        end
        CH_RECIRC: begin
          if (off_done(left)) begin
            st   <= CH_DRIVE;
            left <= '0;
          end else begin
            left <= left - cnt_t'(1);
          end
        end
        default: st <= CH_DRIVE;
      endcase
    end
  end
endmodule

// File: rtl/chop_blank.sv
module chop_blank
  import chop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hs_on,
  input  cnt_t blank_cyc,
  output logic blanking
);
  logic hs_prev;
  logic hs_rise;
  cnt_t cnt;

  assign hs_rise  = hs_on && !hs_prev;
  assign blanking = (hs_rise && blank_cyc != '0) || (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_prev <= 1'b0;
      cnt     <= '0;
    end else begin
      hs_prev <= hs_on;
      if (hs_rise)
        cnt <= blank_load(blank_cyc);
      else if (cnt != '0)
        cnt <= cnt - cnt_t'(1);
    end
  end
endmodule

// File: rtl/chop_decay_sel.sv
module chop_decay_sel #(
  parameter int NPH = 3
) (
  input  logic [NPH-1:0] hi_sel,
  input  logic [NPH-1:0] lo_sel,
  input  logic           src_en,
  input  logic           pwm_in,
  input  logic           slow_decay,
  output logic [NPH-1:0] req_hi,
  output logic [NPH-1:0] req_lo
);
  logic drive;
  assign drive = src_en && pwm_in;

  for (genvar i = 0; i < NPH; i++) begin : g_ph
    always_comb begin
      if (drive) begin
        req_hi[i] = hi_sel[i];
        req_lo[i] = lo_sel[i];
      end else begin
        req_hi[i] = 1'b0;
        req_lo[i] = hi_sel[i] | (slow_decay & lo_sel[i]);
      end
    end
  end
endmodule

// File: rtl/chop_dead_leg.sv
module chop_dead_leg
  import chop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_hi,
  input  logic req_lo,
  input  cnt_t dead_cyc,
  output logic gh,
  output logic gl
);
  cnt_t idle;
  logic gh_n;
  logic gl_n;

  always_comb begin
    gh_n = leg_grant(req_hi, req_lo, gh, gl, idle, dead_cyc);
    gl_n = leg_grant(req_lo, req_hi, gl, gh, idle, dead_cyc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gh   <= 1'b0;
      gl   <= 1'b0;
      idle <= '0;
    end else begin
      gh   <= gh_n;
      gl   <= gl_n;
      idle <= (gh_n || gl_n) ? '0 : sat_inc(idle);
    end
  end
endmodule

// File: rtl/pwm_chopper.sv
module pwm_chopper
  import chop_pkg::*;
#(
  parameter int NPH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NPH-1:0] hi_sel,
  input  logic [NPH-1:0] lo_sel,
  input  logic           pwm_in,
  input  logic           slow_decay,
  input  logic           trip_in,
  input  logic [15:0]    dead_cyc,
  input  logic [15:0]    off_cyc,
  input  logic [15:0]    blank_cyc,
  output logic [NPH-1:0] gate_hi,
  output logic [NPH-1:0] gate_lo
);
  logic           hs_on;
  logic           blanking;
  logic           src_en;
  logic [NPH-1:0] req_hi;
  logic [NPH-1:0] req_lo;

  assign hs_on = |gate_hi;

  chop_blank u_blank (
    .clk       (clk),
    .rst_n     (rst_n),
    .hs_on     (hs_on),
    .blank_cyc (blank_cyc),
    .blanking  (blanking)
  );

  chop_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwm_in   (pwm_in),
    .trip_in  (trip_in),
    .hs_on    (hs_on),
    .blanking (blanking),
    .off_cyc  (off_cyc),
    .src_en   (src_en)
  );

  chop_decay_sel #(.NPH(NPH)) u_decay (
    .hi_sel     (hi_sel),
    .lo_sel     (lo_sel),
    .src_en     (src_en),
    .pwm_in     (pwm_in),
    .slow_decay (slow_decay),
    .req_hi     (req_hi),
    .req_lo     (req_lo)
  );

  for (genvar i = 0; i < NPH; i++) begin : g_leg
    chop_dead_leg u_leg (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_hi   (req_hi[i]),
      .req_lo   (req_lo[i]),
      .dead_cyc (dead_cyc),
      .gh       (gate_hi[i]),
      .gl       (gate_lo[i])
    );
  end
endmodule

// File: rtl/pwm_chopper_chk.sv
module pwm_chopper_chk
  import chop_pkg::*;
#(
  parameter int NPH = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           pwm_in,
  input logic           trip_in,
  input logic [NPH-1:0] gate_hi,
  input logic [NPH-1:0] gate_lo,
  input cnt_t           dead_cyc,
  input cnt_t           off_cyc,
  input logic           src_en,
  input logic           blanking
);
  cnt_t min_gap;
  assign min_gap = (dead_cyc == '0) ? cnt_t'(1) : dead_cyc;

  // R10: no leg ever conducts on both sides
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hi & gate_lo) == '0);

  // R2: accepted trip clears the high side two edges later
  a_r2_trip_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_in && (|gate_hi) && !blanking && src_en && pwm_in) |=> ##1 (gate_hi == '0));

  // R3: drive state cannot end inside the blanking window
  a_r3_blank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (blanking && src_en) |=> src_en);

  // R4: recirculation lasts at least two cycles when off_cyc >= 2
  a_r4_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(src_en) && off_cyc >= cnt_t'(2)) |=> !src_en);

  // R7: PWM low removes the high side on the next edge
  a_r7_pwm_low: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_in |=> (gate_hi == '0));

  for (genvar i = 0; i < NPH; i++) begin : g_gap
    cnt_t run;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        run <= '0;
      else
        run <= (gate_hi[i] || gate_lo[i]) ? '0 : sat_inc(run);
    end
    // R8: a gate rises only after the leg was idle for the dead time
    a_r8_dead_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_hi[i] | gate_lo[i]) |-> (run >= min_gap));
  end
endmodule

bind pwm_chopper pwm_chopper_chk #(.NPH(NPH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pwm_in   (pwm_in),
  .trip_in  (trip_in),
  .gate_hi  (gate_hi),
  .gate_lo  (gate_lo),
  .dead_cyc (dead_cyc),
  .off_cyc  (off_cyc),
  .src_en   (src_en),
  .blanking (blanking)
);

// File: tb/pwm_chopper_test.sv
module pwm_chopper_test;
  localparam int D = 3;
  localparam int T = 10;
  localparam int B = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  hi_sel = 3'b001;
  logic [2:0]  lo_sel = 3'b010;
  logic        pwm_in = 1'b1;
  logic        slow_decay = 1'b1;
  logic        trip_in = 1'b0;
  logic [15:0] dead_cyc = 16'(D);
  logic [15:0] off_cyc = 16'(T);
  logic [15:0] blank_cyc = 16'(B);
  logic [2:0]  gate_hi;
  logic [2:0]  gate_lo;

  int n_chk = 0;
  int n_bad = 0;
  bit overlap_seen = 1'b0;

  always #2 clk = ~clk;

  pwm_chopper uut (
    .clk(clk), .rst_n(rst_n), .hi_sel(hi_sel), .lo_sel(lo_sel),
    .pwm_in(pwm_in), .slow_decay(slow_decay), .trip_in(trip_in),
    .dead_cyc(dead_cyc), .off_cyc(off_cyc), .blank_cyc(blank_cyc),
    .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
      if ((gate_hi & gate_lo) != 3'b000) overlap_seen = 1'b1;
    end
  endtask

  task automatic do_reset(input logic mode);
    rst_n = 1'b0; hi_sel = 3'b001; lo_sel = 3'b010; pwm_in = 1'b1;
    trip_in = 1'b0; slow_decay = mode; dead_cyc = 16'(D);
    off_cyc = 16'(T); blank_cyc = 16'(B);
    step(3);
    chk("R1", "gates in reset", {gate_hi, gate_lo}, 0);
    rst_n = 1'b1;
  endtask

  task automatic bring_up(input logic mode);
    do_reset(mode);
    step(D + 1);
  endtask

  // R1, R8, R11: first turn-on after reset waits the dead time
  task automatic t_startup();
    do_reset(1'b1);
    step(D);
    chk("R1", "gates before dead time", {gate_hi, gate_lo}, 0);
    step(1);
    chk("R11", "gate_hi after start", gate_hi, 3'b001);
    chk("R11", "gate_lo after start", gate_lo, 3'b010);
  endtask

  // R2, R3, R4, R5, R6: held trip, off-time and decay pattern
  task automatic t_trip(input logic mode);
    int n;
    bring_up(mode);
    trip_in = 1'b1;
    n = 0;
    while (gate_hi != 3'b000 && n < 50) begin step(1); n++; end
    chk("R3", "cycles from rise to trip cut", n, B + 2);
    trip_in = 1'b0;
    chk(mode ? "R5" : "R6", "lo at cut", gate_lo, mode ? 3'b010 : 3'b000);
    step(D);
    chk(mode ? "R5" : "R6", "lo in recirculation", gate_lo, mode ? 3'b011 : 3'b001);
    step(T - 1);
    chk("R4", "hi just before return", gate_hi, 3'b000);
    chk("R4", "lo just before return", gate_lo, 3'b010);
    step(1);
    chk("R4", "hi after off-time", gate_hi, 3'b001);
  endtask

  // R3: short trip inside the blanking window is ignored
  task automatic t_blank_pulse();
    bring_up(1'b1);
    step(B - 1);
    trip_in = 1'b1;
    step(1);
    trip_in = 1'b0;
    step(4);
    chk("R3", "hi after trip pulse in blanking", gate_hi, 3'b001);
  endtask

  // R7: PWM low forces decay, trip ignored meanwhile
  task automatic t_pwm();
    bring_up(1'b1);
    step(B + 2);
    pwm_in = 1'b0;
    trip_in = 1'b1;
    step(1);
    chk("R7", "hi one edge after pwm low", gate_hi, 3'b000);
    chk("R7", "lo one edge after pwm low", gate_lo, 3'b010);
    step(D);
    chk("R7", "lo slow decay under pwm low", gate_lo, 3'b011);
    step(5);
    pwm_in = 1'b1;
    trip_in = 1'b0;
    step(D);
    chk("R7", "hi before dead time after pwm high", gate_hi, 3'b000);
    step(1);
    chk("R7", "hi returns without off-time", gate_hi, 3'b001);
  endtask

  // R8, R9: phase change passes through dead time; zero dead time still gaps one cycle
  task automatic t_dir();
    bring_up(1'b1);
    step(B + 2);
    hi_sel = 3'b010;
    lo_sel = 3'b001;
    step(1);
    chk("R9", "all off after phase change", {gate_hi, gate_lo}, 0);
    step(D - 1);
    chk("R9", "still off before dead time", {gate_hi, gate_lo}, 0);
    step(1);
    chk("R9", "new gates after dead time", {gate_hi, gate_lo}, {3'b010, 3'b001});
    dead_cyc = 16'd0;
    hi_sel = 3'b001;
    lo_sel = 3'b010;
    step(1);
    chk("R8", "one idle cycle with zero dead time", {gate_hi, gate_lo}, 0);
    step(1);
    chk("R8", "gates after minimum gap", {gate_hi, gate_lo}, {3'b001, 3'b010});
  endtask

  initial begin
    #(4 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
    $finish;
  end

  initial begin
    t_startup();
    t_trip(1'b1);
    t_trip(1'b0);
    t_blank_pulse();
    t_pwm();
    t_dir();
    chk("R10", "overlap seen on any leg", int'(overlap_seen), 0);
    report();
    $finish;
  end
endmodule